// File: doc/BRIEF.md
# Execute-Stage Operand Forwarding Unit

This block sits in front of the arithmetic unit of an in-order five-stage integer pipeline. For the instruction now in the execute stage, it compares both source register indices against the destination indices of the two older instructions that have not yet retired. One of those is in the memory stage and the other is in the write-back stage. When a source matches a live write, the block routes the in-flight result to the operand in place of the stale register-file read. The memory-stage result is taken when both older instructions match, because it is the younger of the two.

After forwarding, the second operand passes through one more selector. That selector substitutes the decoded immediate for instructions with an immediate operand. The register file writes on the falling clock edge, so the decode stage never needs a path from write-back. The two execute-stage sources are the only consumers that need forwarding. The unit is purely combinational. Load-use stalls and the arithmetic unit itself lie outside it.

Top module: `exu_operand_fwd`

## Requirements
- R1: With no live match from either older stage, each operand equals its register-file read value.
- R2: A source index that equals the memory-stage destination, with the memory-stage write enable high and that destination nonzero, yields the memory-stage result on the operand.
- R3: A source index that matches only the write-back-stage destination, with that stage's write enable high and the destination nonzero, yields the write-back data.
- R4: When both older stages match the same source, the memory-stage result wins over the write-back data.
- R5: A destination index of 0 never causes forwarding, whatever the write enable is, because register 0 always reads as zero.
- R6: A stage whose write enable is low never causes forwarding, whatever its destination index is.
- R7: When the immediate-select input is 1, the second operand equals the immediate, whatever forwarding the second source would have chosen.
- R8: When the immediate-select input is 0, the second operand follows the same forwarding rules (R1 to R6) on the second source index as the first operand does on the first source index.
- R9: The two operands are resolved independently, so they may take values from two different stages in the same cycle.
- R10: The unit can feed a back-to-back chain of dependent additions that alternate between two registers, plus register moves through register 0, and each sum then matches sequential execution.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ex_rs1_idx | input | RIDX | First source register index of the execute-stage instruction |
| ex_rs2_idx | input | RIDX | Second source register index of the execute-stage instruction |
| ex_rf_a | input | XLEN | Register-file value read for the first source |
| ex_rf_b | input | XLEN | Register-file value read for the second source |
| ex_imm | input | XLEN | Decoded immediate of the execute-stage instruction |
| ex_use_imm | input | 1 | 1 selects the immediate as the second operand |
| mem_rd_idx | input | RIDX | Destination index of the memory-stage instruction |
| mem_wr_en | input | 1 | Memory-stage instruction writes a register |
| mem_alu_res | input | XLEN | Arithmetic result latched in the memory stage |
| wb_rd_idx | input | RIDX | Destination index of the write-back-stage instruction |
| wb_wr_en | input | 1 | Write-back-stage instruction writes a register |
| wb_data | input | XLEN | Final selected write-back value |
| alu_op_a | output | XLEN | First operand for the arithmetic unit |
| alu_op_b | output | XLEN | Second operand for the arithmetic unit |

## Verification
The sweep goes after the cases where both older stages name the same register. A design that reversed the priority would hand the execute stage a result that is one instruction too old. It also probes register 0 with its write enable high, where a missing zero guard would forward a value that the architecture discards. It covers live destinations whose write enable is low, where stores and branches would otherwise corrupt operands. Immediate instructions whose second source field happens to collide with a pending write are included too, because a selector placed in the wrong order would let forwarding override the immediate. A dependent addition chain then checks that no stage pairing is dropped, since a dropped pairing shows up at once as a wrong term in the running sums.

// File: rtl/exu_fwd_pkg.sv
package exu_fwd_pkg;

   typedef enum logic [1:0] {
      SRC_REGFILE = 2'd0,
      SRC_MEMSTG  = 2'd1,
      SRC_WBSTG   = 2'd2
   } opnd_src_e;

   localparam int unsigned NUM_OPERANDS = 2;

endpackage

// File: rtl/exu_fwd_detect.sv
module exu_fwd_detect
   import exu_fwd_pkg::*;
#(
   parameter int unsigned RIDX       = 5,
   parameter bit          ZERO_GUARD = 1'b1
) (
   input  logic [RIDX-1:0] src_idx,
   input  logic [RIDX-1:0] mem_dst,
   input  logic            mem_we,
   input  logic [RIDX-1:0] wb_dst,
   input  logic            wb_we,
   output opnd_src_e       src_sel
);

   logic mem_live;
   logic wb_live;
   logic mem_hit;
   logic wb_hit;

   generate
      if (ZERO_GUARD) begin : g_guard
         assign mem_live = mem_we && (mem_dst != '0);
         assign wb_live  = wb_we  && (wb_dst  != '0);
      end else begin : g_noguard
         assign mem_live = mem_we;
         assign wb_live  = wb_we;
      end
   endgenerate

   assign mem_hit = mem_live && (mem_dst == src_idx);
   assign wb_hit  = wb_live  && (wb_dst  == src_idx);

   always_comb begin
      if (mem_hit)
         src_sel = SRC_MEMSTG;
      else if (wb_hit)
         src_sel = SRC_WBSTG;
      else
         src_sel = SRC_REGFILE;
   end

endmodule

// File: rtl/exu_fwd_mux.sv
module exu_fwd_mux
   import exu_fwd_pkg::*;
#(
   parameter int unsigned XLEN = 32
) (
   input  opnd_src_e       sel,
   input  logic [XLEN-1:0] rf_val,
   input  logic [XLEN-1:0] mem_val,
   input  logic [XLEN-1:0] wb_val,
   output logic [XLEN-1:0] y
);

   always_comb begin
      unique case (sel)
         SRC_MEMSTG: y = mem_val;
         SRC_WBSTG:  y = wb_val;
         default:    y = rf_val;
      endcase
   end

endmodule

// File: rtl/exu_imm_sel.sv
module exu_imm_sel #(
   parameter int unsigned XLEN = 32
) (
   input  logic [XLEN-1:0] fwd_val,
   input  logic [XLEN-1:0] imm_val,
   input  logic            use_imm,
   output logic [XLEN-1:0] y
);

   assign y = use_imm ? imm_val : fwd_val;

endmodule

// File: rtl/exu_operand_fwd.sv
module exu_operand_fwd
   import exu_fwd_pkg::*;
#(
   parameter int unsigned XLEN       = 32,
   parameter int unsigned NREGS      = 32,
   parameter bit          ZERO_GUARD = 1'b1,
   localparam int unsigned RIDX      = $clog2(NREGS)
) (
   input  logic [RIDX-1:0] ex_rs1_idx,
   input  logic [RIDX-1:0] ex_rs2_idx,
   input  logic [XLEN-1:0] ex_rf_a,
   input  logic [XLEN-1:0] ex_rf_b,
   input  logic [XLEN-1:0] ex_imm,
   input  logic            ex_use_imm,
   input  logic [RIDX-1:0] mem_rd_idx,
   input  logic            mem_wr_en,
   input  logic [XLEN-1:0] mem_alu_res,
   input  logic [RIDX-1:0] wb_rd_idx,
   input  logic            wb_wr_en,
   input  logic [XLEN-1:0] wb_data,
   output logic [XLEN-1:0] alu_op_a,
   output logic [XLEN-1:0] alu_op_b
);

   generate
      if (XLEN < 8) begin : g_bad_xlen
         $error("exu_operand_fwd: XLEN must be at least 8");
      end
      if (NREGS < 2 || (NREGS & (NREGS - 1)) != 0) begin : g_bad_nregs
         $error("exu_operand_fwd: NREGS must be a power of two >= 2");
      end
   endgenerate

   logic [RIDX-1:0] src_idx [NUM_OPERANDS];
   logic [XLEN-1:0] rf_val  [NUM_OPERANDS];
   logic [XLEN-1:0] fwd_val [NUM_OPERANDS];
   opnd_src_e       src_sel [NUM_OPERANDS];

   assign src_idx[0] = ex_rs1_idx;
   assign src_idx[1] = ex_rs2_idx;
   assign rf_val[0]  = ex_rf_a;
   assign rf_val[1]  = ex_rf_b;

   genvar gi;
   generate
      for (gi = 0; gi < NUM_OPERANDS; gi++) begin : g_opnd
         exu_fwd_detect #(
            .RIDX       (RIDX),
            .ZERO_GUARD (ZERO_GUARD)
         ) u_det (
            .src_idx (src_idx[gi]),
            .mem_dst (mem_rd_idx),
            .mem_we  (mem_wr_en),
            .wb_dst  (wb_rd_idx),
            .wb_we   (wb_wr_en),
            .src_sel (src_sel[gi])
         );

         exu_fwd_mux #(
            .XLEN (XLEN)
         ) u_mux (
            .sel     (src_sel[gi]),
            .rf_val  (rf_val[gi]),
            .mem_val (mem_alu_res),
            .wb_val  (wb_data),
            .y       (fwd_val[gi])
         );
      end
   endgenerate

   assign alu_op_a = fwd_val[0];

   exu_imm_sel #(
      .XLEN (XLEN)
   ) u_imm (
      .fwd_val (fwd_val[1]),
      .imm_val (ex_imm),
      .use_imm (ex_use_imm),
      .y       (alu_op_b)
   );

endmodule

// File: rtl/exu_operand_fwd_chk.sv
module exu_operand_fwd_chk #(
   parameter int unsigned XLEN       = 32,
   parameter int unsigned RIDX       = 5,
   parameter bit          ZERO_GUARD = 1'b1
) (
   input logic [RIDX-1:0] ex_rs1_idx,
   input logic [RIDX-1:0] ex_rs2_idx,
   input logic [XLEN-1:0] ex_rf_a,
   input logic [XLEN-1:0] ex_rf_b,
   input logic [XLEN-1:0] ex_imm,
   input logic            ex_use_imm,
   input logic [RIDX-1:0] mem_rd_idx,
   input logic            mem_wr_en,
   input logic [XLEN-1:0] mem_alu_res,
   input logic [RIDX-1:0] wb_rd_idx,
   input logic            wb_wr_en,
   input logic [XLEN-1:0] wb_data,
   input logic [XLEN-1:0] alu_op_a,
   input logic [XLEN-1:0] alu_op_b
);

   logic m_ok, w_ok, m_a, w_a, m_b, w_b;

   assign m_ok = mem_wr_en && (!ZERO_GUARD || mem_rd_idx != '0);
   assign w_ok = wb_wr_en  && (!ZERO_GUARD || wb_rd_idx  != '0);
   assign m_a  = m_ok && mem_rd_idx == ex_rs1_idx;
   assign w_a  = w_ok && wb_rd_idx  == ex_rs1_idx;
   assign m_b  = m_ok && mem_rd_idx == ex_rs2_idx;
   assign w_b  = w_ok && wb_rd_idx  == ex_rs2_idx;

   always_comb begin
      if (!m_a && !w_a)
         p_pass_rf_r1: assert (alu_op_a == ex_rf_a);
      if (m_a && !w_a)
         p_mem_fwd_r2: assert (alu_op_a == mem_alu_res);
      if (w_a && !m_a)
         p_wb_fwd_r3: assert (alu_op_a == wb_data);
      if (m_a && w_a)
         p_mem_over_wb_r4: assert (alu_op_a == mem_alu_res);
      if (ZERO_GUARD && ex_rs1_idx == '0)
         p_zero_rd_r5: assert (alu_op_a == ex_rf_a);
      if (!mem_wr_en && !wb_wr_en)
         p_we_low_r6: assert (alu_op_a == ex_rf_a && (ex_use_imm || alu_op_b == ex_rf_b));
      if (ex_use_imm)
         p_imm_sel_r7: assert (alu_op_b == ex_imm);
      if (!ex_use_imm && m_b)
         p_b_mem_r8: assert (alu_op_b == mem_alu_res);
   end

endmodule

bind exu_operand_fwd exu_operand_fwd_chk #(
   .XLEN       (XLEN),
   .RIDX       (RIDX),
   .ZERO_GUARD (ZERO_GUARD)
) u_chk (
   .ex_rs1_idx  (ex_rs1_idx),
   .ex_rs2_idx  (ex_rs2_idx),
   .ex_rf_a     (ex_rf_a),
   .ex_rf_b     (ex_rf_b),
   .ex_imm      (ex_imm),
   .ex_use_imm  (ex_use_imm),
   .mem_rd_idx  (mem_rd_idx),
   .mem_wr_en   (mem_wr_en),
   .mem_alu_res (mem_alu_res),
   .wb_rd_idx   (wb_rd_idx),
   .wb_wr_en    (wb_wr_en),
   .wb_data     (wb_data),
   .alu_op_a    (alu_op_a),
   .alu_op_b    (alu_op_b)
);

// File: tb/sim_exu_operand_fwd.sv
module sim_exu_operand_fwd;

   localparam int XW = 32;
   localparam int RW = 5;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic [RW-1:0] ex_rs1_idx, ex_rs2_idx, mem_rd_idx, wb_rd_idx;
   logic [XW-1:0] ex_rf_a, ex_rf_b, ex_imm, mem_alu_res, wb_data;
   logic          ex_use_imm, mem_wr_en, wb_wr_en;
   logic [XW-1:0] alu_op_a, alu_op_b;

   int n_run  = 0;
   int n_fail = 0;

   exu_operand_fwd #(.XLEN(XW), .NREGS(32), .ZERO_GUARD(1'b1)) u0 (
      .ex_rs1_idx  (ex_rs1_idx),
      .ex_rs2_idx  (ex_rs2_idx),
      .ex_rf_a     (ex_rf_a),
      .ex_rf_b     (ex_rf_b),
      .ex_imm      (ex_imm),
      .ex_use_imm  (ex_use_imm),
      .mem_rd_idx  (mem_rd_idx),
      .mem_wr_en   (mem_wr_en),
      .mem_alu_res (mem_alu_res),
      .wb_rd_idx   (wb_rd_idx),
      .wb_wr_en    (wb_wr_en),
      .wb_data     (wb_data),
      .alu_op_a    (alu_op_a),
      .alu_op_b    (alu_op_b)
   );

   task automatic check(input string req, input logic [XW-1:0] act, input logic [XW-1:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
      end
   endtask

   // Reference: src 0 = register file, 1 = memory stage, 2 = write-back stage
   function automatic int ref_src(input int rs, input int mrd, input bit mwe,
                                  input int wrd, input bit wwe, output string tag);
      bit mh = mwe && mrd != 0 && mrd == rs;
      bit wh = wwe && wrd != 0 && wrd == rs;
      if (mh && wh) begin tag = "R4"; return 1; end
      if (mh)       begin tag = "R2"; return 1; end
      if (wh)       begin tag = "R3"; return 2; end
      if ((mwe && mrd == rs) || (wwe && wrd == rs)) tag = "R5";
      else if (mrd == rs || wrd == rs)             tag = "R6";
      else                                         tag = "R1";
      return 0;
   endfunction

   // Fibonacci-style program storage
   int p_rs1 [0:31];
   int p_rs2 [0:31];
   int p_rd  [0:31];
   bit p_imm [0:31];
   logic [XW-1:0] p_ival [0:31];

   initial begin : watchdog
      #(5.0 * 190000);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin : main
      int np;
      logic [XW-1:0] gold [0:7];
      logic [XW-1:0] rf [0:7];
      int ex_i, mem_rd, wb_rd;
      bit ex_v, mem_we, wb_we;
      logic [XW-1:0] ex_a, ex_b, mem_res, wb_d, res;
      logic [XW-1:0] exp_res [0:31];

      // quiet start: everything zero
      ex_rs1_idx = '0; ex_rs2_idx = '0; mem_rd_idx = '0; wb_rd_idx = '0;
      ex_rf_a = '0; ex_rf_b = '0; ex_imm = '0; mem_alu_res = '0; wb_data = '0;
      ex_use_imm = 1'b0; mem_wr_en = 1'b0; wb_wr_en = 1'b0;
      @(negedge clk);
      check("R1 idle", alu_op_a, '0);
      check("R1 idle", alu_op_b, '0);

      // Near-exhaustive sweep over registers 0..7
      for (int rs1 = 0; rs1 < 8; rs1++)
      for (int rs2 = 0; rs2 < 8; rs2++)
      for (int mrd = 0; mrd < 8; mrd++)
      for (int wrd = 0; wrd < 8; wrd++)
      for (int we = 0; we < 4; we++) begin
         string ta, tb;
         int sa, sb;
         bit ui;
         logic [XW-1:0] ea, eb;
         logic [XW-1:0] stg [0:2];
         @(posedge clk);
         ui = ((rs1 + rs2 + mrd + wrd + we) % 3) == 0;
         ex_rs1_idx  = RW'(rs1);
         ex_rs2_idx  = RW'(rs2);
         mem_rd_idx  = RW'(mrd);
         wb_rd_idx   = RW'(wrd);
         mem_wr_en   = we[0];
         wb_wr_en    = we[1];
         ex_use_imm  = ui;
         ex_rf_a     = 32'h1000_0000 + XW'(rs1);
         ex_rf_b     = 32'h2000_0000 + XW'(rs2);
         mem_alu_res = 32'h3000_0000 + XW'(mrd);
         wb_data     = 32'h4000_0000 + XW'(wrd);
         ex_imm      = 32'h5000_0000 + XW'(rs1 * 64 + rs2 * 8 + we);
         stg[1] = mem_alu_res;
         stg[2] = wb_data;
         sa = ref_src(rs1, mrd, we[0], wrd, we[1], ta);
         sb = ref_src(rs2, mrd, we[0], wrd, we[1], tb);
         stg[0] = ex_rf_a; ea = stg[sa];
         stg[0] = ex_rf_b; eb = stg[sb];
         @(negedge clk);
         check({ta, " op_a"}, alu_op_a, ea);
         if (ui)
            check("R7 imm", alu_op_b, ex_imm);
         else if (sa != 0 && sb != 0 && sa != sb)
            check("R9 split", alu_op_b, eb);
         else
            check({"R8 ", tb}, alu_op_b, eb);
      end

      // R10: dependent chain x1/x2 alternating, with moves into x3 via x0
      np = 0;
      p_rd[np] = 2; p_rs1[np] = 0; p_rs2[np] = 0; p_imm[np] = 1; p_ival[np] = 1; np++;
      for (int k = 0; k < 6; k++) begin
         p_rd[np] = 1; p_rs1[np] = 1; p_rs2[np] = 2; p_imm[np] = 0; p_ival[np] = 0; np++;
         p_rd[np] = 3; p_rs1[np] = 0; p_rs2[np] = 1; p_imm[np] = 0; p_ival[np] = 0; np++;
         p_rd[np] = 2; p_rs1[np] = 2; p_rs2[np] = 1; p_imm[np] = 0; p_ival[np] = 0; np++;
         p_rd[np] = 3; p_rs1[np] = 0; p_rs2[np] = 2; p_imm[np] = 0; p_ival[np] = 0; np++;
      end
      for (int r = 0; r < 8; r++) begin gold[r] = '0; rf[r] = '0; end
      for (int i = 0; i < np; i++) begin
         exp_res[i] = gold[p_rs1[i]] + (p_imm[i] ? p_ival[i] : gold[p_rs2[i]]);
         if (p_rd[i] != 0) gold[p_rd[i]] = exp_res[i];
      end

      ex_v = 0; ex_i = 0; ex_a = '0; ex_b = '0;
      mem_we = 0; mem_rd = 0; mem_res = '0;
      wb_we = 0; wb_rd = 0; wb_d = '0;
      for (int t = 0; t < np + 3; t++) begin
         @(posedge clk);
         if (wb_we && wb_rd != 0) rf[wb_rd] = wb_d;   // falling-edge write
         ex_rs1_idx  = RW'(ex_v ? p_rs1[ex_i] : 0);
         ex_rs2_idx  = RW'(ex_v ? p_rs2[ex_i] : 0);
         ex_rf_a     = ex_a;
         ex_rf_b     = ex_b;
         ex_use_imm  = ex_v && p_imm[ex_i];
         ex_imm      = ex_v ? p_ival[ex_i] : '0;
         mem_rd_idx  = RW'(mem_rd);
         mem_wr_en   = mem_we;
         mem_alu_res = mem_res;
         wb_rd_idx   = RW'(wb_rd);
         wb_wr_en    = wb_we;
         wb_data     = wb_d;
         @(negedge clk);
         res = alu_op_a + alu_op_b;
         if (ex_v) check("R10 chain", res, exp_res[ex_i]);
         wb_we = mem_we; wb_rd = mem_rd; wb_d = mem_res;
         mem_we = ex_v; mem_rd = ex_v ? p_rd[ex_i] : 0; mem_res = res;
         if (t < np) begin
            ex_v = 1; ex_i = t;
            ex_a = rf[p_rs1[t]];
            ex_b = rf[p_rs2[t]];
         end else begin
            ex_v = 0; ex_a = '0; ex_b = '0;
         end
      end

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule